// File: doc/BRIEF.md
# Burst Address Generator

This block produces the word address that one port of a dual-ported memory presents to its decode logic. A port either supplies a fresh address from outside or lets the block generate the following addresses by itself. When the address strobe is low at a clock edge, the external address is taken for that access and also loaded into an internal counter. While count enable is held low, the counter advances by one word on every rising edge. This allows a burst of successive words to be read or written without driving new addresses. A counter-clear input returns the counter to address zero.

All three controls are active low. They are resolved by a fixed priority. Clear beats everything. Strobe beats count enable. Count enable acts only when both clear and strobe are high. When none of the three is asserted, the counter keeps its value.

The counter spans the whole array. After the top word it rolls over to zero. The output address is the counter register itself, so the address chosen at an edge appears right after that edge.

The asynchronous reset `rst_n` is expected to arrive already released in step with `clk`.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, `addr_out` is zero.
- R2: With `zero_n` high and `strobe_n` low at a rising edge, `addr_out` equals the `addr_in` sampled at that edge from that edge onward.
- R3: With `zero_n` and `strobe_n` high and `step_n` low at a rising edge, `addr_out` becomes its previous value plus one.
- R4: `step_n` has no effect in a cycle where `strobe_n` is low; the loaded value is exactly `addr_in`, not `addr_in` plus one.
- R5: `step_n` has no effect in a cycle where `zero_n` is low; the result is zero, not one.
- R6: `zero_n` low at a rising edge makes `addr_out` zero, whatever `strobe_n`, `step_n` and `addr_in` are.
- R7: A step from address DEPTH-1 gives address 0.
- R8: With `zero_n`, `strobe_n` and `step_n` all high at a rising edge, `addr_out` is unchanged.
- R9: Holding `step_n` low for N consecutive edges advances `addr_out` by N modulo DEPTH, one word per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| strobe_n | input | 1 | Address strobe, active low: use and load `addr_in` |
| step_n | input | 1 | Count enable, active low: advance by one word |
| zero_n | input | 1 | Counter clear, active low, highest priority |
| addr_in | input | AW = clog2(DEPTH) | External word address |
| addr_out | output | AW | Address presented to the memory decode |

## Verification
The output is the counter register itself, so any wrong counter state shows on `addr_out` in the cycle right after the edge that produced it. A mis-ordered priority shows up as an address one word too high: after a strobe combined with count enable, or a clear combined with count enable. A faulty wraparound shows up as a non-zero address after stepping from the top word. Because every later step is relative to the stored value, a single bad update stays visible on every following cycle until the next load or clear.

// File: rtl/bac_pkg.sv
package bac_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_STEP  = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } bac_op_e;
endpackage

// File: rtl/bac_prio.sv
module bac_prio
  import bac_pkg::*;
(
  input  logic    strobe_n,
  input  logic    step_n,
  input  logic    zero_n,
  output bac_op_e op
);
  // Clear first, then strobe, then count enable.
  always_comb begin
    if (!zero_n)        op = OP_CLEAR;
    else if (!strobe_n) op = OP_LOAD;
    else if (!step_n)   op = OP_STEP;
    else                op = OP_HOLD;
  end
endmodule

// File: rtl/bac_next.sv
module bac_next
  import bac_pkg::*;
#(
  parameter int DEPTH = 32768,
  parameter int AW    = $clog2(DEPTH)
) (
  input  bac_op_e         op,
  input  logic [AW-1:0]   cur,
  input  logic [AW-1:0]   ext,
  output logic [AW-1:0]   nxt,
  output logic            upd
);
  localparam logic [AW-1:0] TOP  = AW'(DEPTH - 1);
  localparam bit            POW2 = (DEPTH == (1 << AW));

  logic [AW-1:0] inc;

  generate
    if (POW2) begin : g_natural_wrap
      always_comb inc = cur + AW'(1);
    end else begin : g_compare_wrap
      always_comb inc = (cur == TOP) ? '0 : cur + AW'(1);
    end
  endgenerate

  always_comb begin
    upd = (op != OP_HOLD);
    unique case (op)
      OP_CLEAR: nxt = '0;
      OP_LOAD:  nxt = ext;
      OP_STEP:  nxt = inc;
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/bac_reg.sv
module bac_reg #(
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [AW-1:0] d,
  output logic [AW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bac_pkg::*;
#(
  parameter int DEPTH = 32768,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe_n,
  input  logic          step_n,
  input  logic          zero_n,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_out
);
  bac_op_e       op;
  logic [AW-1:0] cnt_q;
  logic [AW-1:0] cnt_d;
  logic          cnt_en;

  bac_prio u_prio (
    .strobe_n (strobe_n),
    .step_n   (step_n),
    .zero_n   (zero_n),
    .op       (op)
  );

  bac_next #(.DEPTH(DEPTH), .AW(AW)) u_next (
    .op  (op),
    .cur (cnt_q),
    .ext (addr_in),
    .nxt (cnt_d),
    .upd (cnt_en)
  );

  bac_reg #(.AW(AW)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (cnt_en),
    .d     (cnt_d),
    .q     (cnt_q)
  );

  assign addr_out = cnt_q;
endmodule

// File: rtl/bac_chk.sv
module bac_chk #(
  parameter int DEPTH = 32768,
  parameter int AW    = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          strobe_n,
  input logic          step_n,
  input logic          zero_n,
  input logic [AW-1:0] addr_in,
  input logic [AW-1:0] addr_out
);
  localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_n |-> addr_out == '0);

  // Also covers R4: step_n is a don't-care here.
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_n && !strobe_n) |=> addr_out == $past(addr_in));

  // Also covers R7: the step from TOP lands on zero.
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_n && strobe_n && !step_n) |=>
      addr_out == (($past(addr_out) == TOP) ? '0 : $past(addr_out) + AW'(1)));

  // Also covers R5: clear wins over count enable.
  p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !zero_n |=> addr_out == '0);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_n && strobe_n && step_n) |=> $stable(addr_out));
endmodule

bind burst_addr_gen bac_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .strobe_n (strobe_n),
  .step_n   (step_n),
  .zero_n   (zero_n),
  .addr_in  (addr_in),
  .addr_out (addr_out)
);

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 32768;
  localparam int AW         = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          strobe_n, step_n, zero_n;
  logic [AW-1:0] addr_in;
  logic [AW-1:0] addr_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [AW-1:0] exp_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_gen #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .step_n(step_n),
    .zero_n(zero_n), .addr_in(addr_in), .addr_out(addr_out)
  );

  function automatic logic [AW-1:0] model(logic [AW-1:0] cur, logic z,
                                          logic s, logic e, logic [AW-1:0] x);
    if (!z)      return '0;
    else if (!s) return x;
    else if (!e) return (cur == AW'(DEPTH - 1)) ? '0 : cur + AW'(1);
    else         return cur;
  endfunction

  function automatic string tag(logic z, logic s, logic e);
    if (!z)      return e ? "R6" : "R5";
    else if (!s) return e ? "R2" : "R4";
    else if (!e) return "R3";
    else         return "R8";
  endfunction

  task automatic check(string req, logic [AW-1:0] exp);
    checks++;
    if (addr_out !== exp) begin
      errors++;
      $display("FAIL %s addr_out=%0h expected=%0h", req, addr_out, exp);
    end
  endtask

  // Drive on the falling edge, compare shortly after the rising edge.
  task automatic cycle(logic z, logic s, logic e, logic [AW-1:0] x, string req);
    @(negedge clk);
    zero_n = z; strobe_n = s; step_n = e; addr_in = x;
    exp_addr = model(exp_addr, z, s, e, x);
    @(posedge clk);
    #1;
    check(req.len() != 0 ? req : tag(z, s, e), exp_addr);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'h5eed_2024;
    void'($urandom(seed));
    rst_n = 1'b0; zero_n = 1'b1; strobe_n = 1'b1; step_n = 1'b1; addr_in = '0;
    exp_addr = '0;
    repeat (3) @(posedge clk);
    #1 check("R1", '0);
    @(negedge clk) rst_n = 1'b1;

    cycle(1, 0, 1, AW'(16'h1234), "R2");
    for (int i = 0; i < 5; i++) cycle(1, 1, 0, '0, "R9");
    if (addr_out === AW'(16'h1239)) checks++;
    else begin
      checks++; errors++;
      $display("FAIL R9 addr_out=%0h expected=1239", addr_out);
    end
    cycle(1, 1, 1, AW'(16'h7777), "R8");
    cycle(1, 1, 1, '0, "R8");
    cycle(1, 0, 0, AW'(16'h0a00), "R4");
    cycle(1, 1, 0, '0, "R3");
    cycle(0, 0, 0, AW'(16'h5555), "R5");
    cycle(0, 1, 1, '0, "R6");
    cycle(1, 0, 1, AW'(DEPTH - 2), "R2");
    cycle(1, 1, 0, '0, "R7");
    cycle(1, 1, 0, '0, "R7");
    cycle(1, 1, 0, '0, "R3");

    for (int i = 0; i < 600; i++) begin
      logic z, s, e;
      z = ($urandom % 10) != 0;
      s = ($urandom % 5) != 0;
      e = ($urandom % 3) == 0;
      cycle(z, s, e, AW'($urandom), "");
    end

    cycle(1, 0, 1, AW'(DEPTH - 3), "R2");
    for (int i = 0; i < 6; i++) cycle(1, 1, 0, '0, "R9");

    @(negedge clk) rst_n = 1'b0;
    #1 check("R1", '0);
    exp_addr = '0;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule